// File: doc/BRIEF.md
# Variable-Length XXTEA Cipher Core

This block encrypts or decrypts a single message with the Corrected Block TEA algorithm. The message is two to eight 32-bit words long and the key is always 128 bits. The caller presents the whole message in parallel, together with a word count, a mode bit and the key, and pulses `start`. The core captures the message into a chain of word registers and performs one partial round per clock. The result is then presented in parallel together with a one-cycle `done` pulse.

A round over an n-word message is made of n partial rounds. The number of rounds is 6 + floor(52/n). The word registers form a shifting chain. In each cycle the word at the head is updated and written to the tail while the other words move one place toward the head. The MX function therefore always reads the same three positions. Decryption loads the message into the chain in reversed order, and swaps the y and z operands of MX. This lets the same datapath handle both directions. The round sum is kept in a register. In encryption it starts at DELTA and DELTA is added after each round. In decryption it starts at q*DELTA, taken from a small selector, and DELTA is subtracted after each round.

The controller has three states:
- `ST_IDLE`: waits for `start`. A start in this state loads the chain and moves to `ST_RUN`.
- `ST_RUN`: performs one partial round per cycle. After the last partial round of the last round it moves to `ST_FLAG`.
- `ST_FLAG`: raises `done` for one cycle and returns to `ST_IDLE`.

Top module: `xxtea_core`

## Requirements
- R1: `word_count` (4 bits) gives n, the number of 32-bit message words. Values 2..8 are used as given. Values 0 and 1 behave exactly like 2, and values 9..15 behave exactly like 8.
- R2: If `start` is sampled high at a rising edge while idle, `done` is high during the cycle that follows the n*q-th later rising edge, where q = 6 + floor(52/n). This is one partial round per clock.
- R3: With `decrypt`=0 the result is the XXTEA encryption of words 0..n-1. MX is (((z>>5)^(y<<2))+((y>>3)^(z<<4)))^((sum^y)+(key[(p&3)^e]^z)), with e = sum[3:2], DELTA = 0x9E3779B9, and words updated in ascending order by adding MX. With key FFFFFFFF x4, the input A8137C15, 575EBA50, 91776D30 must give EF1C60B2, 72B778B0, 6ABACCAB.
- R4: With `decrypt`=1 the result is the XXTEA decryption: words are updated in descending order by subtracting MX, and sum starts at q*DELTA. Decrypting an encryption result under the same key and n returns the original words.
- R5: Message word i occupies `msg_in[32*i+31:32*i]`, key word k occupies `key[32*k+31:32*k]`, and result word i occupies `msg_out[32*i+31:32*i]`. Key word selection follows R3 for keys with distinct words.
- R6: Message words at indices n and above have no effect on the result.
- R7: Result words at indices n and above read zero. `msg_out` holds its value from the `done` cycle until the next accepted start, whatever the other inputs do.
- R8: A `start` pulse while `busy` is high is ignored. The running operation ends with the same result and latency as without the pulse.
- R9: `done` is high for exactly one cycle. `busy` is high from the cycle after the accepted start through the `done` cycle, and low afterwards.
- R10: After reset `busy` and `done` are low and `msg_out` is all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation when idle |
| decrypt | input | 1 | 0 = encrypt, 1 = decrypt |
| word_count | input | 4 | Number of message words n |
| key | input | 128 | 128-bit key, word k at bits 32k+31:32k |
| msg_in | input | 256 | Message, word i at bits 32i+31:32i |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| msg_out | output | 256 | Result words, unused words zero |

## Verification
The bench builds the core with its default of eight message words and a 4-bit count. With these values every legal length from 2 to 8 can be exercised. The count can also be driven to 0, 1 and 9 to 15, which brings the clamping on both sides within reach. Encryption results are compared against a model written in the bench from the algorithm definition, for every length and for two keys. Decryption is checked both on the fixed vector and as a round trip. The bench also measures latency in cycles against n*q. It checks that upper words are ignored, that a mid-run start is ignored, and that the result holds after `done`.

// File: rtl/xxtea_pkg.sv
package xxtea_pkg;
    localparam int WORD_W = 32;
    localparam logic [WORD_W-1:0] DELTA = 32'h9E3779B9;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_FLAG
    } state_t;

    // full rounds for an n-word message
    function automatic int rounds_for(input int n);
        return 6 + 52 / n;
    endfunction
endpackage

// File: rtl/xxtea_mx.sv
module xxtea_mx
    import xxtea_pkg::*;
(
    input  word_t y_i,
    input  word_t z_i,
    input  word_t sum_i,
    input  word_t key_i,
    output word_t mx_o
);
    word_t mix_a;
    word_t mix_b;

    always_comb begin
        mix_a = ((z_i >> 5) ^ (y_i << 2)) + ((y_i >> 3) ^ (z_i << 4));
        mix_b = (sum_i ^ y_i) + (key_i ^ z_i);
        mx_o  = mix_a ^ mix_b;
    end
endmodule

// File: rtl/xxtea_keysched.sv
module xxtea_keysched
    import xxtea_pkg::*;
#(
    parameter int MIN_WORDS = 2,
    parameter int MAX_WORDS = 8,
    parameter int CNT_W     = $clog2(MAX_WORDS + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic               ld_dec_i,
    input  logic [CNT_W-1:0]   ld_n_i,
    input  logic               dec_i,
    input  logic               step_i,
    input  logic [1:0]         pidx_i,
    input  logic [4*WORD_W-1:0] key_i,
    output word_t              sum_o,
    output word_t              key_o
);
    word_t sum_q;
    word_t start_sum;

    // q*DELTA chosen from a small set of constants instead of a multiplier
    function automatic word_t dec_start(input logic [CNT_W-1:0] n);
        word_t r;
        r = word_t'(rounds_for(MIN_WORDS)) * DELTA;
        for (int k = MIN_WORDS; k <= MAX_WORDS; k++) begin
            if (int'(n) == k) r = word_t'(rounds_for(k)) * DELTA;
        end
        return r;
    endfunction

    always_comb begin
        start_sum = ld_dec_i ? dec_start(ld_n_i) : DELTA;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_q <= '0;
        end else if (load_i) begin
            sum_q <= start_sum;
        end else if (step_i) begin
            sum_q <= dec_i ? (sum_q - DELTA) : (sum_q + DELTA);
        end
    end

    logic [1:0] sel;
    always_comb begin
        sel   = pidx_i ^ sum_q[3:2];
        key_o = key_i[32*sel +: 32];
        sum_o = sum_q;
    end
endmodule

// File: rtl/xxtea_chain.sv
module xxtea_chain
    import xxtea_pkg::*;
#(
    parameter int MAX_WORDS = 8,
    parameter int CNT_W     = $clog2(MAX_WORDS + 1),
    localparam int BUS_W    = MAX_WORDS * WORD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             ld_rev_i,
    input  logic [CNT_W-1:0] ld_n_i,
    input  logic [BUS_W-1:0] msg_i,
    input  logic             shift_i,
    input  logic             rev_i,
    input  logic [CNT_W-1:0] n_i,
    input  word_t            new_i,
    output word_t            head_o,
    output word_t            next_o,
    output word_t            tail_o,
    output logic [BUS_W-1:0] out_o
);
    word_t slot_q   [MAX_WORDS];
    word_t load_val [MAX_WORDS];

    // load mapping: straight for encryption, reversed for decryption
    always_comb begin
        for (int i = 0; i < MAX_WORDS; i++) begin
            load_val[i] = '0;
            if (i < int'(ld_n_i)) begin
                for (int j = 0; j < MAX_WORDS; j++) begin
                    if ((ld_rev_i ? (int'(ld_n_i) - 1 - i) : i) == j)
                        load_val[i] = msg_i[32*j +: 32];
                end
            end
        end
    end

    generate
        for (genvar gi = 0; gi < MAX_WORDS; gi++) begin : g_slot
            localparam int NXT = (gi < MAX_WORDS - 1) ? gi + 1 : gi;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    slot_q[gi] <= '0;
                end else if (load_i) begin
                    slot_q[gi] <= load_val[gi];
                end else if (shift_i) begin
                    if (gi == int'(n_i) - 1)
                        slot_q[gi] <= new_i;
                    else if (gi < int'(n_i) - 1)
                        slot_q[gi] <= slot_q[NXT];
                end
            end
        end
    endgenerate

    always_comb begin
        head_o = slot_q[0];
        next_o = slot_q[1];
        tail_o = slot_q[0];
        for (int i = 0; i < MAX_WORDS; i++) begin
            if (i == int'(n_i) - 1) tail_o = slot_q[i];
        end
        out_o = '0;
        for (int i = 0; i < MAX_WORDS; i++) begin
            if (i < int'(n_i)) begin
                for (int j = 0; j < MAX_WORDS; j++) begin
                    if ((rev_i ? (int'(n_i) - 1 - i) : i) == j)
                        out_o[32*i +: 32] = slot_q[j];
                end
            end
        end
    end

    // R7: with neither load nor shift the presented result holds
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !shift_i) |=> $stable(out_o));
endmodule

// File: rtl/xxtea_core.sv
module xxtea_core
    import xxtea_pkg::*;
#(
    parameter int MIN_WORDS = 2,
    parameter int MAX_WORDS = 8,
    localparam int CNT_W    = $clog2(MAX_WORDS + 1),
    localparam int PCNT_W   = (MAX_WORDS > 4) ? $clog2(MAX_WORDS) : 2,
    localparam int RCNT_W   = $clog2(6 + 52 / MIN_WORDS + 1),
    localparam int BUS_W    = MAX_WORDS * WORD_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               decrypt,
    input  logic [CNT_W-1:0]   word_count,
    input  logic [4*WORD_W-1:0] key,
    input  logic [BUS_W-1:0]   msg_in,
    output logic               busy,
    output logic               done,
    output logic [BUS_W-1:0]   msg_out
);
    state_t             state_q, state_d;
    logic               dec_q;
    logic [CNT_W-1:0]   n_q;
    logic [CNT_W-1:0]   n_clamp;
    logic [PCNT_W-1:0]  pcnt_q;
    logic [RCNT_W-1:0]  rcnt_q;
    logic               load, run, last_part, last_round;
    logic [1:0]         pidx;
    word_t              head, nxt, tail, y_op, z_op, mx, sum, kword, upd;

    function automatic int q_of(input logic [CNT_W-1:0] n);
        int r;
        r = rounds_for(MIN_WORDS);
        for (int k = MIN_WORDS; k <= MAX_WORDS; k++) begin
            if (int'(n) == k) r = rounds_for(k);
        end
        return r;
    endfunction

    always_comb begin
        if (int'(word_count) < MIN_WORDS)      n_clamp = CNT_W'(MIN_WORDS);
        else if (int'(word_count) > MAX_WORDS) n_clamp = CNT_W'(MAX_WORDS);
        else                                   n_clamp = word_count;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_RUN;
            ST_RUN:  if (last_part && last_round) state_d = ST_FLAG;
            ST_FLAG: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs and control strobes
    always_comb begin
        busy       = (state_q != ST_IDLE);
        done       = (state_q == ST_FLAG);
        load       = (state_q == ST_IDLE) && start;
        run        = (state_q == ST_RUN);
        last_part  = (int'(pcnt_q) == int'(n_q) - 1);
        last_round = (int'(rcnt_q) == q_of(n_q) - 1);
        pidx       = dec_q ? 2'(int'(n_q) - 1 - int'(pcnt_q)) : 2'(pcnt_q);
    end

    // sequencing counters and captured settings
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_q  <= 1'b0;
            n_q    <= CNT_W'(MIN_WORDS);
            pcnt_q <= '0;
            rcnt_q <= '0;
        end else if (load) begin
            dec_q  <= decrypt;
            n_q    <= n_clamp;
            pcnt_q <= '0;
            rcnt_q <= '0;
        end else if (run) begin
            if (last_part) begin
                pcnt_q <= '0;
                rcnt_q <= rcnt_q + 1'b1;
            end else begin
                pcnt_q <= pcnt_q + 1'b1;
            end
        end
    end

    xxtea_chain #(.MAX_WORDS(MAX_WORDS), .CNT_W(CNT_W)) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load),
        .ld_rev_i (decrypt),
        .ld_n_i   (n_clamp),
        .msg_i    (msg_in),
        .shift_i  (run),
        .rev_i    (dec_q),
        .n_i      (n_q),
        .new_i    (upd),
        .head_o   (head),
        .next_o   (nxt),
        .tail_o   (tail),
        .out_o    (msg_out)
    );

    xxtea_keysched #(.MIN_WORDS(MIN_WORDS), .MAX_WORDS(MAX_WORDS), .CNT_W(CNT_W)) u_keys (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load),
        .ld_dec_i (decrypt),
        .ld_n_i   (n_clamp),
        .dec_i    (dec_q),
        .step_i   (run && last_part),
        .pidx_i   (pidx),
        .key_i    (key),
        .sum_o    (sum),
        .key_o    (kword)
    );

    // operand swap: the newest word is z when encrypting, y when decrypting
    always_comb begin
        y_op = dec_q ? tail : nxt;
        z_op = dec_q ? nxt  : tail;
        upd  = dec_q ? (head - mx) : (head + mx);
    end

    xxtea_mx u_mx (
        .y_i   (y_op),
        .z_i   (z_op),
        .sum_i (sum),
        .key_i (kword),
        .mx_o  (mx)
    );

    // R9: completion flag lasts one cycle
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8: captured settings do not move during a run
    assert_ignore_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> ($stable(n_q) && $stable(dec_q)));
    // R1: captured length is always legal
    assert_count_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (int'(n_q) >= MIN_WORDS && int'(n_q) <= MAX_WORDS));
    // R2: partial index never reaches n
    assert_partial_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (int'(pcnt_q) < int'(n_q)));
    // R3: after q encryption rounds the sum has advanced q times beyond DELTA
    assert_enc_sum_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !dec_q) |-> (sum == word_t'(q_of(n_q) + 1) * DELTA));
    // R4: decryption walks the sum back to zero
    assert_dec_sum_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && dec_q) |-> (sum == '0));
endmodule

// File: tb/test_xxtea_core.sv
`timescale 1ns/1ps
module test_xxtea_core;
    localparam int MW = 8;
    localparam int BW = MW * 32;
    localparam logic [31:0] DLT = 32'h9E3779B9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          decrypt = 1'b0;
    logic [3:0]    word_count = 4'd2;
    logic [127:0]  key = '0;
    logic [BW-1:0] msg_in = '0;
    logic          busy, done;
    logic [BW-1:0] msg_out;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    xxtea_core i_xxtea_core (
        .clk(clk), .rst_n(rst_n), .start(start), .decrypt(decrypt),
        .word_count(word_count), .key(key), .msg_in(msg_in),
        .busy(busy), .done(done), .msg_out(msg_out)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [BW-1:0] act, input logic [BW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mxf(input logic [31:0] z, input logic [31:0] y,
                                        input logic [31:0] s, input logic [31:0] k);
        return (((z >> 5) ^ (y << 2)) + ((y >> 3) ^ (z << 4))) ^ ((s ^ y) + (k ^ z));
    endfunction

    // encryption model from the algorithm definition
    function automatic logic [BW-1:0] ref_enc(input int n, input logic [127:0] k,
                                              input logic [BW-1:0] m);
        logic [31:0] v [MW];
        logic [31:0] z, y, s;
        logic [BW-1:0] r;
        int e;
        for (int i = 0; i < MW; i++) v[i] = m[32*i +: 32];
        s = 0;
        z = v[n-1];
        for (int q = 0; q < 6 + 52 / n; q++) begin
            s = s + DLT;
            e = int'(s[3:2]);
            for (int p = 0; p < n; p++) begin
                y = (p == n - 1) ? v[0] : v[p+1];
                v[p] = v[p] + mxf(z, y, s, k[32*((p & 3) ^ e) +: 32]);
                z = v[p];
            end
        end
        r = '0;
        for (int i = 0; i < n; i++) r[32*i +: 32] = v[i];
        return r;
    endfunction

    function automatic logic [BW-1:0] pattern(input int seed, input int n);
        logic [BW-1:0] r;
        r = '0;
        for (int i = 0; i < n; i++)
            r[32*i +: 32] = (32'(seed) * 32'h2545F491) ^ (32'(i + 1) * 32'h9E3779B1) ^ 32'h5A5A0F0F;
        return r;
    endfunction

    task automatic run_op(input logic dec, input logic [3:0] cnt, input logic [127:0] k,
                          input logic [BW-1:0] m, output logic [BW-1:0] res, output int lat);
        @(negedge clk);
        decrypt = dec; word_count = cnt; key = k; msg_in = m; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        for (int t = 0; t < 2000; t++) begin
            @(negedge clk);
            lat++;
            if (done) break;
        end
        res = msg_out;
    endtask

    task automatic t_reset();
        check(busy == 1'b0, "R10", "busy after reset", BW'(busy), '0);
        check(done == 1'b0, "R10", "done after reset", BW'(done), '0);
        check(msg_out == '0, "R10", "result after reset", msg_out, '0);
    endtask

    task automatic t_known();
        logic [BW-1:0] pt, ct, res;
        int lat;
        pt = '0; ct = '0;
        pt[31:0] = 32'hA8137C15; pt[63:32] = 32'h575EBA50; pt[95:64] = 32'h91776D30;
        ct[31:0] = 32'hEF1C60B2; ct[63:32] = 32'h72B778B0; ct[95:64] = 32'h6ABACCAB;
        run_op(1'b0, 4'd3, {4{32'hFFFFFFFF}}, pt, res, lat);
        check(res == ct, "R3", "known vector encrypt", res, ct);
        check(lat == 3 * 23, "R2", "latency n=3", BW'(lat), BW'(69));
        run_op(1'b1, 4'd3, {4{32'hFFFFFFFF}}, ct, res, lat);
        check(res == pt, "R4", "known vector decrypt", res, pt);
        check(lat == 69, "R2", "decrypt latency n=3", BW'(lat), BW'(69));
    endtask

    task automatic t_lengths(input logic [127:0] k, input int seed);
        logic [BW-1:0] m, exp, res, back;
        int lat;
        for (int n = 2; n <= MW; n++) begin
            m = pattern(seed + n, n);
            exp = ref_enc(n, k, m);
            run_op(1'b0, 4'(n), k, m, res, lat);
            check(res == exp, "R5", $sformatf("encrypt n=%0d", n), res, exp);
            check(lat == n * (6 + 52 / n), "R2", $sformatf("latency n=%0d", n),
                  BW'(lat), BW'(n * (6 + 52 / n)));
            run_op(1'b1, 4'(n), k, res, back, lat);
            check(back == m, "R4", $sformatf("round trip n=%0d", n), back, m);
        end
    endtask

    task automatic t_ignore_upper();
        logic [127:0] k;
        logic [BW-1:0] m, junk, exp, res;
        int lat;
        k = {32'h0F1E2D3C, 32'h4B5A6978, 32'h8796A5B4, 32'hC3D2E1F0};
        m = pattern(77, 4);
        junk = m;
        for (int i = 4; i < MW; i++) junk[32*i +: 32] = 32'hDEAD0000 + 32'(i);
        exp = ref_enc(4, k, m);
        run_op(1'b0, 4'd4, k, junk, res, lat);
        check(res == exp, "R6", "upper words ignored, encrypt", res, exp);
        run_op(1'b1, 4'd4, k, exp | (junk & ~m), res, lat);
        check(res == m, "R6", "upper words ignored, decrypt", res, m);
        check(res[BW-1:128] == '0, "R7", "unused result words zero",
              BW'(res[BW-1:128]), '0);
    endtask

    task automatic t_clamp();
        logic [127:0] k;
        logic [BW-1:0] m, exp, res;
        int lat;
        k = {32'h11111111, 32'h22222222, 32'h33333333, 32'h44444444};
        m = pattern(5, 8);
        exp = ref_enc(2, k, m);
        run_op(1'b0, 4'd1, k, m, res, lat);
        check(res == exp, "R1", "count 1 acts as 2", res, exp);
        run_op(1'b0, 4'd0, k, m, res, lat);
        check(res == exp, "R1", "count 0 acts as 2", res, exp);
        check(lat == 64, "R1", "count 0 latency", BW'(lat), BW'(64));
        exp = ref_enc(8, k, m);
        run_op(1'b0, 4'd12, k, m, res, lat);
        check(res == exp, "R1", "count 12 acts as 8", res, exp);
        run_op(1'b0, 4'd15, k, m, res, lat);
        check(lat == 96, "R1", "count 15 latency", BW'(lat), BW'(96));
    endtask

    task automatic t_busy_start();
        logic [127:0] k;
        logic [BW-1:0] m, exp;
        int lat;
        k = {32'hCAFEF00D, 32'h01234567, 32'h89ABCDEF, 32'h76543210};
        m = pattern(9, 6);
        exp = ref_enc(6, k, m);
        @(negedge clk);
        decrypt = 1'b0; word_count = 4'd6; key = k; msg_in = m; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        for (int t = 0; t < 2000; t++) begin
            @(negedge clk);
            lat++;
            if (lat == 1)
                check(busy == 1'b1, "R9", "busy after start", BW'(busy), BW'(1));
            if (lat == 20) begin
                start = 1'b1; decrypt = 1'b1; word_count = 4'd2; msg_in = pattern(99, 8);
            end
            if (lat == 21) start = 1'b0;
            if (done) break;
        end
        check(msg_out == exp, "R8", "mid-run start ignored", msg_out, exp);
        check(lat == 6 * 14, "R8", "mid-run start latency", BW'(lat), BW'(84));
        check(busy == 1'b1, "R9", "busy in done cycle", BW'(busy), BW'(1));
        @(negedge clk);
        check(done == 1'b0, "R9", "done single cycle", BW'(done), '0);
        check(busy == 1'b0, "R9", "busy low after done", BW'(busy), '0);
        msg_in = pattern(123, 8); key = ~key; decrypt = 1'b0; word_count = 4'd3;
        for (int t = 0; t < 5; t++) @(negedge clk);
        check(msg_out == exp, "R7", "result held after done", msg_out, exp);
    endtask

    initial begin
        for (int t = 0; t < 150000; t++) begin
            @(posedge clk);
            if (finished) break;
        end
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_known();
        t_lengths({32'h80C0E0F0, 32'hF8FCFEFF, 32'h80402010, 32'h08040201}, 1);
        t_lengths({32'h13579BDF, 32'h2468ACE0, 32'hFEDCBA98, 32'h0BADBEEF}, 40);
        t_ignore_upper();
        t_clamp();
        t_busy_start();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule